// File: doc/BRIEF.md
# Address Latch and Program Fetch Strobe Generator

This block produces the two bus strobes of an 8051-style controller from the oscillator clock. A twelve-state counter divides each machine cycle into oscillator periods. Two address-latch pulses are emitted per machine cycle, in states 0 and 6, so the latch strobe runs at one sixth of the oscillator rate. While the core fetches code from external memory, an active-low program-fetch strobe fires twice per machine cycle, in states 3 and 9. A machine cycle that the core marks as an external data access loses its first latch pulse and both of its fetch pulses.

Software can silence the latch strobe by writing 1 to bit 0 of the control byte at address 8EH. The pin is then left to a weak pullup, and the block reports this on a separate flag. The disable does not apply during a data-move or code-read instruction, in idle, in power-down, in emulation mode, or while code runs from external memory. Idle parks both strobes high and power-down parks both strobes low.

Top module: `ale_strobe_gen`

## Requirements
- R1: Under normal conditions `ale` is high for exactly two oscillator periods in every six, which gives two pulses per twelve-state machine cycle: 8 rising edges and 16 high samples in any 48 consecutive periods.
- R2: `xdata_cyc` is sampled as each machine cycle begins. When it is sampled high, the state-0 latch pulse of that machine cycle is omitted and the state-6 pulse still appears. Holding the flag high for 12 consecutive periods gives 7 rising edges in a 48-period window.
- R3: With `ext_exec` high, `psen_n` goes low twice per machine cycle, for two periods each time (8 falls and 16 low samples in 48 periods). With `ext_exec` low, `psen_n` stays high.
- R4: In a machine cycle flagged as an external data access, both fetch pulses are omitted (6 falls and 12 low samples in a 48-period window holding one such cycle).
- R5: A write with `reg_wr` high and `reg_addr` equal to 8EH loads `reg_wdata` into the disable bit. `reg_rdata` returns that bit when `reg_addr` is 8EH and returns 0 at any other address. A write to any other address leaves the bit unchanged.
- R6: When the disable bit is set and no exception applies, `ale` is held at 1 and `ale_weak` is 1.
- R7: While `mov_instr` or `emu_mode` is high, the disable is suspended: `ale` pulses as in R1 and `ale_weak` is 0.
- R8: While `idle` is high and `pdown` is low, `ale` and `psen_n` are both held at 1 and `ale_weak` is 0.
- R9: While `pdown` is high, `ale` and `psen_n` are both held at 0 and `ale_weak` is 0. `pdown` takes priority over `idle`.
- R10: While `ext_exec` is high, the disable bit has no effect: `ale` pulses and `ale_weak` is 0.
- R11: Reset clears the disable bit and drives `ale` to 0, `psen_n` to 1 and `ale_weak` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, one state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| xdata_cyc | input | 1 | Current machine cycle is an external data access |
| mov_instr | input | 1 | A data-move or code-read instruction is executing |
| idle | input | 1 | Idle mode |
| pdown | input | 1 | Power-down mode |
| emu_mode | input | 1 | Emulation mode |
| ext_exec | input | 1 | Code is being fetched from external memory |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 1 | Write value for the disable bit |
| reg_rdata | output | 1 | Disable bit readback (0 at other addresses) |
| ale | output | 1 | Address-latch strobe level |
| psen_n | output | 1 | Program-fetch strobe, active low |
| ale_weak | output | 1 | Latch pin is held only by the weak pullup |

## Verification
The assertions assume that every mode flag, the data-cycle flag and the register port are synchronous to the oscillator clock. Each flag's effect is checked one edge after the level is sampled. The mode flags are not assumed to be mutually exclusive, because the priority order settles any overlap. The stimulus changes inputs only on falling clock edges, holds each mode level for the whole of a counting window, and raises the data-cycle flag for exactly twelve periods, so that exactly one machine-cycle start sees it. Edge and level counts over windows that are multiples of six periods make the expected values independent of where the phase counter stands.

// File: rtl/ale_pkg.sv
package ale_pkg;
  localparam int unsigned OSC_PER_MC = 12;
  localparam int unsigned STROBE_W   = 2;

  typedef struct packed {
    logic pdown;
    logic idle;
    logic emu;
    logic mov;
    logic ext;
  } ale_mode_t;
endpackage

// File: rtl/ale_rst_sync.sv
module ale_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = sh_q << 1;
    sh_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/ale_phase_gen.sv
module ale_phase_gen #(
  parameter int unsigned STATES = ale_pkg::OSC_PER_MC,
  parameter int unsigned PH_W   = $clog2(STATES)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph_nxt
);
  localparam logic [PH_W-1:0] LAST = PH_W'(STATES - 1);

  logic [PH_W-1:0] ph_q;

  always_comb begin
    if (ph_q == LAST) ph_nxt = '0;
    else              ph_nxt = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= LAST;
    else        ph_q <= ph_nxt;
  end

  // R1: the state counter walks 0..STATES-1 and wraps
  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == LAST) |=> (ph_q == '0));
  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != LAST) |=> (ph_q == $past(ph_q) + 1'b1));
endmodule

// File: rtl/ale_ctl_reg.sv
module ale_ctl_reg #(
  parameter int unsigned     AW   = 8,
  parameter logic [AW-1:0]   ADDR = AW'(8'h8E)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wdata,
  output logic          reg_rdata,
  output logic          dis_q
);
  logic hit;
  logic wr_en;
  logic dis_d;

  always_comb begin
    hit   = (reg_addr == ADDR);
    wr_en = reg_wr & hit;
    dis_d = wr_en ? reg_wdata : dis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dis_q <= 1'b0;
    else        dis_q <= dis_d;
  end

  assign reg_rdata = hit & dis_q;

  // R5: a decoded write loads the bit, anything else keeps it
  p_write_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR) |=> (dis_q == $past(reg_wdata)));
  p_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR) |=> $stable(dis_q));
endmodule

// File: rtl/ale_strobe_out.sv
module ale_strobe_out
  import ale_pkg::*;
#(
  parameter int unsigned STATES   = OSC_PER_MC,
  parameter int unsigned PULSE_W  = STROBE_W,
  parameter int unsigned ALE_OFS  = 0,
  parameter int unsigned PSEN_OFS = 3,
  parameter int unsigned PH_W     = $clog2(STATES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ph_nxt,
  input  logic            xdata_cyc,
  input  ale_mode_t       mode,
  input  logic            dis,
  output logic            ale,
  output logic            psen_n,
  output logic            ale_weak
);
  localparam int unsigned HALF  = STATES / 2;
  localparam int unsigned NSLOT = 2;

  logic [NSLOT-1:0] ale_hit;
  logic [NSLOT-1:0] psen_hit;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      localparam int unsigned A0 = ALE_OFS + g * HALF;
      localparam int unsigned P0 = PSEN_OFS + g * HALF;
      assign ale_hit[g]  = (32'(ph_nxt) >= A0) && (32'(ph_nxt) < A0 + PULSE_W);
      assign psen_hit[g] = (32'(ph_nxt) >= P0) && (32'(ph_nxt) < P0 + PULSE_W);
    end
  endgenerate

  logic xd_q, xd_d;
  logic ale_q, ale_d;
  logic psen_q, psen_d;
  logic weak_q, weak_d;
  logic mc_start;
  logic dis_eff;
  logic ale_run;

  always_comb begin
    mc_start = (ph_nxt == '0);
    xd_d     = mc_start ? xdata_cyc : xd_q;
    dis_eff  = dis & ~(mode.mov | mode.idle | mode.pdown | mode.emu | mode.ext);
    ale_run  = (ale_hit[0] & ~xd_d) | ale_hit[1];

    if (mode.pdown)     ale_d = 1'b0;
    else if (mode.idle) ale_d = 1'b1;
    else if (dis_eff)   ale_d = 1'b1;
    else                ale_d = ale_run;

    if (mode.pdown)                           psen_d = 1'b0;
    else if (mode.idle)                       psen_d = 1'b1;
    else if (mode.ext && (|psen_hit) && !xd_d) psen_d = 1'b0;
    else                                      psen_d = 1'b1;

    weak_d = dis_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xd_q   <= 1'b0;
      ale_q  <= 1'b0;
      psen_q <= 1'b1;
      weak_q <= 1'b0;
    end else begin
      xd_q   <= xd_d;
      ale_q  <= ale_d;
      psen_q <= psen_d;
      weak_q <= weak_d;
    end
  end

  assign ale      = ale_q;
  assign psen_n   = psen_q;
  assign ale_weak = weak_q;

  // R6: a weakly held pin always reads high
  p_weak_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ale_weak |-> ale);
  // R3: no fetch strobe without external execution
  p_psen_internal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.ext && !mode.pdown) |=> psen_n);
  // R7: instruction and emulation exceptions drop the weak hold
  p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.mov || mode.emu) |=> !ale_weak);
  // R8: idle parks both strobes high
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.idle && !mode.pdown) |=> (ale && psen_n && !ale_weak));
  // R9: power-down parks both strobes low
  p_pdown_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode.pdown |=> (!ale && !psen_n && !ale_weak));
  // R10: external execution overrides the disable
  p_ext_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode.ext |=> !ale_weak);
endmodule

// File: rtl/ale_strobe_gen.sv
module ale_strobe_gen
  import ale_pkg::*;
#(
  parameter int unsigned   STATES    = OSC_PER_MC,
  parameter int unsigned   AW        = 8,
  parameter logic [AW-1:0] CTL_ADDR  = AW'(8'h8E),
  parameter int unsigned   SYNC_STG  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xdata_cyc,
  input  logic          mov_instr,
  input  logic          idle,
  input  logic          pdown,
  input  logic          emu_mode,
  input  logic          ext_exec,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wdata,
  output logic          reg_rdata,
  output logic          ale,
  output logic          psen_n,
  output logic          ale_weak
);
  localparam int unsigned PH_W = $clog2(STATES);

  logic            rst_i_n;
  logic [PH_W-1:0] ph_nxt;
  logic            dis_q;
  ale_mode_t       mode;

  always_comb begin
    mode.pdown = pdown;
    mode.idle  = idle;
    mode.emu   = emu_mode;
    mode.mov   = mov_instr;
    mode.ext   = ext_exec;
  end

  ale_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i_n)
  );

  ale_phase_gen #(.STATES(STATES), .PH_W(PH_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .ph_nxt (ph_nxt)
  );

  ale_ctl_reg #(.AW(AW), .ADDR(CTL_ADDR)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dis_q     (dis_q)
  );

  ale_strobe_out #(.STATES(STATES), .PH_W(PH_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .ph_nxt    (ph_nxt),
    .xdata_cyc (xdata_cyc),
    .mode      (mode),
    .dis       (dis_q),
    .ale       (ale),
    .psen_n    (psen_n),
    .ale_weak  (ale_weak)
  );
endmodule

// File: tb/test_ale_strobe_gen.sv
module test_ale_strobe_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, xdata_cyc, mov_instr, idle, pdown, emu_mode, ext_exec;
  logic       reg_wr, reg_wdata, reg_rdata, ale, psen_n, ale_weak;
  logic [7:0] reg_addr;

  ale_strobe_gen i_ale_strobe_gen (
    .clk(clk), .rst_n(rst_n), .xdata_cyc(xdata_cyc), .mov_instr(mov_instr),
    .idle(idle), .pdown(pdown), .emu_mode(emu_mode), .ext_exec(ext_exec),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ale(ale), .psen_n(psen_n), .ale_weak(ale_weak)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic win(input int n, input int xd_len,
                     output int rises, output int highs,
                     output int pfalls, output int plows, output int weaks);
    logic pa, pp;
    pa = ale; pp = psen_n;
    rises = 0; highs = 0; pfalls = 0; plows = 0; weaks = 0;
    if (xd_len > 0) xdata_cyc = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == xd_len - 1) xdata_cyc = 1'b0;
      if (ale && !pa) rises++;
      if (ale) highs++;
      if (!psen_n && pp) pfalls++;
      if (!psen_n) plows++;
      if (ale_weak) weaks++;
      pa = ale; pp = psen_n;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset_state;
    int v;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11", "ale in reset", int'(ale), 0);
    chk("R11", "psen_n in reset", int'(psen_n), 1);
    chk("R11", "ale_weak in reset", int'(ale_weak), 0);
    rd(8'h8E, v);
    chk("R11", "disable bit in reset", v, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_normal;
    int r, h, pf, pl, w;
    win(48, 0, r, h, pf, pl, w);
    chk("R1", "latch rises in 48", r, 8);
    chk("R1", "latch high samples in 48", h, 16);
    chk("R3", "fetch lows without ext", pl, 0);
  endtask

  task automatic t_xdata_skip;
    int r, h, pf, pl, w;
    win(48, 12, r, h, pf, pl, w);
    chk("R2", "latch rises with one data cycle", r, 7);
    chk("R2", "latch highs with one data cycle", h, 14);
  endtask

  task automatic t_psen;
    int r, h, pf, pl, w;
    ext_exec = 1'b1;
    repeat (2) @(negedge clk);
    win(48, 0, r, h, pf, pl, w);
    chk("R3", "fetch falls in 48", pf, 8);
    chk("R3", "fetch lows in 48", pl, 16);
    win(48, 12, r, h, pf, pl, w);
    chk("R4", "fetch falls with data cycle", pf, 6);
    chk("R4", "fetch lows with data cycle", pl, 12);
    ext_exec = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_disable;
    int r, h, pf, pl, w, v;
    wr(8'h8E, 1'b1);
    rd(8'h8E, v);
    chk("R5", "readback after write", v, 1);
    repeat (3) @(negedge clk);
    win(24, 0, r, h, pf, pl, w);
    chk("R6", "latch rises while disabled", r, 0);
    chk("R6", "latch highs while disabled", h, 24);
    chk("R6", "weak samples while disabled", w, 24);
  endtask

  task automatic t_other_addr;
    int v, r, h, pf, pl, w;
    wr(8'h8D, 1'b0);
    rd(8'h8D, v);
    chk("R5", "read at other address", v, 0);
    rd(8'h8E, v);
    chk("R5", "bit after stray write", v, 1);
    win(12, 0, r, h, pf, pl, w);
    chk("R5", "still weak after stray write", w, 12);
  endtask

  task automatic t_override(input string nm);
    int r, h, pf, pl, w;
    repeat (2) @(negedge clk);
    win(24, 0, r, h, pf, pl, w);
    chk("R7", {nm, " latch rises"}, r, 4);
    chk("R7", {nm, " weak samples"}, w, 0);
  endtask

  task automatic t_mov;
    mov_instr = 1'b1; t_override("mov"); mov_instr = 1'b0;
  endtask

  task automatic t_emu;
    emu_mode = 1'b1; t_override("emu"); emu_mode = 1'b0;
  endtask

  task automatic t_ext_dis;
    int r, h, pf, pl, w;
    ext_exec = 1'b1;
    repeat (2) @(negedge clk);
    win(24, 0, r, h, pf, pl, w);
    chk("R10", "latch rises ext with disable", r, 4);
    chk("R10", "weak ext with disable", w, 0);
    ext_exec = 1'b0;
  endtask

  task automatic t_idle;
    int r, h, pf, pl, w;
    idle = 1'b1; ext_exec = 1'b1;
    repeat (2) @(negedge clk);
    win(24, 0, r, h, pf, pl, w);
    chk("R8", "latch highs in idle", h, 24);
    chk("R8", "fetch lows in idle", pl, 0);
    chk("R8", "weak in idle", w, 0);
  endtask

  task automatic t_pdown;
    int r, h, pf, pl, w;
    pdown = 1'b1;
    repeat (2) @(negedge clk);
    win(24, 0, r, h, pf, pl, w);
    chk("R9", "latch highs in power-down", h, 0);
    chk("R9", "fetch lows in power-down", pl, 24);
    chk("R9", "weak in power-down", w, 0);
    pdown = 1'b0; idle = 1'b0; ext_exec = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_clears;
    int v, r, h, pf, pl, w;
    do_reset();
    rd(8'h8E, v);
    chk("R11", "disable cleared by reset", v, 0);
    win(24, 0, r, h, pf, pl, w);
    chk("R11", "latch rises after reset", r, 4);
    chk("R11", "weak after reset", w, 0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; xdata_cyc = 1'b0; mov_instr = 1'b0; idle = 1'b0; pdown = 1'b0;
    emu_mode = 1'b0; ext_exec = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_normal();
    t_xdata_skip();
    t_psen();
    t_disable();
    t_other_addr();
    t_mov();
    t_emu();
    t_ext_dis();
    t_idle();
    t_pdown();
    t_reset_clears();
    done = 1;
    summary();
    $finish;
  end
endmodule